// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block turns a logical byte address into a physical byte address through a single-level page table that lives in ordinary memory. The page size is a power of two, so no divider is needed. The page number is the upper part of the logical address and the byte offset is the lower part. A pair of configuration registers holds the byte address of the table in memory and the number of valid entries in it.

A request is offered with a valid/ready handshake. The unit first compares the page number with the entry count. A page outside the table ends the request at once with a fault, and memory is never touched. A page inside the table causes one read of the entry at `base + page * entry_bytes` through a read port whose data comes back one cycle after the request. The low bits of that entry give the frame number. The frame number is joined to the untouched offset to form the physical address, which is returned with a one-cycle done pulse.

Top module: `page_xlate`

## Requirements
- R1: After reset `req_ready_o` is 1, and `rsp_done_o`, `rsp_fault_o` and `mem_req_o` are 0.
- R2: On a translation without a fault, `rsp_paddr_o[PAGE_BITS-1:0]` equals the low `PAGE_BITS` bits of the accepted logical address.
- R3: If the page number (`vaddr >> PAGE_BITS`) is greater than or equal to the entry count, the response carries `rsp_fault_o`=1 and `rsp_paddr_o`=0. The done pulse comes in the second cycle after acceptance, and `mem_req_o` is not raised for that request.
- R4: For a page inside the table, `mem_req_o` is high for exactly one cycle, in the cycle after acceptance, with `mem_addr_o` = table base + page * `PTE_BYTES` (page shifted left by log2 of `PTE_BYTES`, modulo 2^`PA_W`).
- R5: The frame number is entry bits `[PA_W-PAGE_BITS-1:0]`. The physical address is frame * 2^`PAGE_BITS` + offset. The response has `rsp_fault_o`=0, and its done pulse comes two cycles after `mem_req_o`, because read data is sampled the cycle after the request.
- R6: With 1 KiB pages (`PAGE_BITS`=10), a table whose entry for page 2 holds frame 8 translates logical address 2500 into physical address 8644.
- R7: `req_ready_o` is 1 only while no request is in flight. A request offered while busy is not accepted and produces no response and no memory read.
- R8: A configuration write (`cfg_we_i`) takes effect only in a cycle where the unit is idle and no request is being accepted. A write in any other cycle is dropped.
- R9: `rsp_done_o` is a single-cycle pulse, one for each accepted request. `rsp_fault_o` is only ever high together with it.
- R10: An entry count of 0 faults every page. Page count-1 is still translated. An entry count of 2^(`VA_W`-`PAGE_BITS`) lets the top page of the logical space translate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write table base and entry count |
| cfg_base_i | input | PA_W | Table byte address to write |
| cfg_len_i | input | VA_W-PAGE_BITS+1 | Entry count to write |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Unit idle, request taken this cycle if valid |
| req_vaddr_i | input | VA_W | Logical byte address |
| rsp_done_o | output | 1 | One-cycle response pulse |
| rsp_fault_o | output | 1 | Page outside table (with done) |
| rsp_paddr_o | output | PA_W | Physical byte address (0 on fault) |
| mem_req_o | output | 1 | Entry read strobe |
| mem_addr_o | output | PA_W | Entry byte address |
| mem_rdata_i | input | 8*PTE_BYTES | Entry data, valid the cycle after mem_req_o |

## Verification
The table walk is tried with the 2500→8644 worked case and with page 0 of a table. It is also tried with the last page inside a table and the first page past it, with a zero-length table, with a full-length table holding an all-ones address, and with a large base. These separate a `>` comparison from a `>=` comparison, a truncated page number from a full one, and a faulting path from one that still fetches. The memory model returns an entry derived from the address it was given and returns garbage in every other cycle. A wrong entry address, or sampling read data in the wrong cycle, therefore shows up as a wrong frame. Directed cases then offer a second request and configuration writes while the unit is busy and in the accepting cycle, and observe whether later translations change.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_LOOKUP = 2'd1,
    XS_WAIT   = 2'd2
  } xlate_state_e;
endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs #(
  parameter int PA_W  = 32,
  parameter int LEN_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PA_W-1:0]  base_o,
  output logic [LEN_W-1:0] len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      len_o  <= '0;
    end else if (wr_en_i) begin
      base_o <= base_i;
      len_o  <= len_i;
    end
  end
endmodule

// File: rtl/pt_index.sv
module pt_index #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 10,
  parameter int PTE_BYTES = 4
) (
  input  logic [VA_W-1:0]           vaddr_i,
  input  logic [PA_W-1:0]           base_i,
  input  logic [VA_W-PAGE_BITS:0]   len_i,
  output logic                      oob_o,
  output logic [PA_W-1:0]           pte_addr_o
);
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PTE_SH = $clog2(PTE_BYTES);
  localparam int EXT_W  = PA_W + VPN_W;

  logic [VPN_W-1:0] vpn;
  logic [EXT_W-1:0] vpn_ext;
  logic [EXT_W-1:0] vpn_scaled;
  logic [PAGE_BITS-1:0] unused_off;

  assign vpn        = vaddr_i[VA_W-1:PAGE_BITS];
  assign unused_off = vaddr_i[PAGE_BITS-1:0];
  assign oob_o      = {1'b0, vpn} >= len_i;
  assign vpn_ext    = {{PA_W{1'b0}}, vpn};

  generate
    if (PTE_SH == 0) begin : g_byte_pte
      assign vpn_scaled = vpn_ext;
    end else begin : g_wide_pte
      assign vpn_scaled = vpn_ext << PTE_SH;
    end
  endgenerate

  assign pte_addr_o = base_i + vpn_scaled[PA_W-1:0];
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import page_xlate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic oob_i,
  output logic ready_o,
  output logic capture_o,
  output logic fetch_o,
  output logic finish_hit_o,
  output logic finish_fault_o
);
  xlate_state_e state_q, state_d;

  always_comb begin
    state_d        = state_q;
    ready_o        = 1'b0;
    capture_o      = 1'b0;
    fetch_o        = 1'b0;
    finish_hit_o   = 1'b0;
    finish_fault_o = 1'b0;
    unique case (state_q)
      XS_IDLE: begin
        ready_o = 1'b1;
        if (req_valid_i) begin
          capture_o = 1'b1;
          state_d   = XS_LOOKUP;
        end
      end
      XS_LOOKUP: begin
        if (oob_i) begin
          finish_fault_o = 1'b1;
          state_d        = XS_IDLE;
        end else begin
          fetch_o = 1'b1;
          state_d = XS_WAIT;
        end
      end
      XS_WAIT: begin
        finish_hit_o = 1'b1;
        state_d      = XS_IDLE;
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= XS_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 10,
  parameter int PTE_BYTES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [PA_W-1:0]          cfg_base_i,
  input  logic [VA_W-PAGE_BITS:0]  cfg_len_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [VA_W-1:0]          req_vaddr_i,
  output logic                     rsp_done_o,
  output logic                     rsp_fault_o,
  output logic [PA_W-1:0]          rsp_paddr_o,
  output logic                     mem_req_o,
  output logic [PA_W-1:0]          mem_addr_o,
  input  logic [8*PTE_BYTES-1:0]   mem_rdata_i
);
  localparam int LEN_W   = VA_W - PAGE_BITS + 1;
  localparam int FRAME_W = PA_W - PAGE_BITS;
  localparam int PTE_W   = 8 * PTE_BYTES;

  logic [PA_W-1:0]    base_q;
  logic [LEN_W-1:0]   len_q;
  logic [VA_W-1:0]    vaddr_q;
  logic               oob;
  logic               capture, fetch, fin_hit, fin_fault;
  logic [FRAME_W-1:0] frame;
  logic               done_q, fault_q;
  logic [PA_W-1:0]    paddr_q;

  // request wins over a config write in the same cycle
  pt_cfg_regs #(.PA_W(PA_W), .LEN_W(LEN_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_we_i & req_ready_o & ~req_valid_i),
    .base_i  (cfg_base_i),
    .len_i   (cfg_len_i),
    .base_o  (base_q),
    .len_o   (len_q)
  );

  pt_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .oob_i          (oob),
    .ready_o        (req_ready_o),
    .capture_o      (capture),
    .fetch_o        (fetch),
    .finish_hit_o   (fin_hit),
    .finish_fault_o (fin_fault)
  );

  pt_index #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PTE_BYTES(PTE_BYTES)
  ) u_index (
    .vaddr_i    (vaddr_q),
    .base_i     (base_q),
    .len_i      (len_q),
    .oob_o      (oob),
    .pte_addr_o (mem_addr_o)
  );

  generate
    if (PTE_W > FRAME_W) begin : g_pte_wide
      logic [PTE_W-FRAME_W-1:0] unused_pte_hi;
      assign frame         = mem_rdata_i[FRAME_W-1:0];
      assign unused_pte_hi = mem_rdata_i[PTE_W-1:FRAME_W];
    end else if (PTE_W == FRAME_W) begin : g_pte_exact
      assign frame = mem_rdata_i;
    end else begin : g_pte_narrow
      assign frame = {{(FRAME_W-PTE_W){1'b0}}, mem_rdata_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vaddr_q <= '0;
    else if (capture) vaddr_q <= req_vaddr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      done_q  <= fin_hit | fin_fault;
      fault_q <= fin_fault;
      if (fin_fault)    paddr_q <= '0;
      else if (fin_hit) paddr_q <= {frame, vaddr_q[PAGE_BITS-1:0]};
    end
  end

  assign mem_req_o   = fetch;
  assign rsp_done_o  = done_q;
  assign rsp_fault_o = fault_q;
  assign rsp_paddr_o = paddr_q;
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_ready_o,
  input logic                    mem_req_o,
  input logic                    rsp_done_o,
  input logic                    rsp_fault_o,
  input logic [PA_W-1:0]         rsp_paddr_o,
  input logic [PA_W-1:0]         base_q,
  input logic [VA_W-PAGE_BITS:0] len_q,
  input logic [VA_W-1:0]         vaddr_q
);
  p_fault_no_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && rsp_fault_o) |-> !$past(mem_req_o));

  p_single_fetch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_fetch_to_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!rsp_done_o ##1 (rsp_done_o && !rsp_fault_o)));

  p_offset_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && !rsp_fault_o) |-> rsp_paddr_o[PAGE_BITS-1:0] == vaddr_q[PAGE_BITS-1:0]);

  p_busy_not_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  p_cfg_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> ($stable(len_q) && $stable(base_q)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  p_fault_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_done_o && rsp_paddr_o == '0));
endmodule

bind page_xlate page_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .rsp_done_o  (rsp_done_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_paddr_o (rsp_paddr_o),
  .base_q      (base_q),
  .len_q       (len_q),
  .vaddr_q     (vaddr_q)
);

// File: tb/tb_page_xlate.sv
module tb_page_xlate;
  localparam int VA_W = 32, PA_W = 32, PAGE_BITS = 10, PTE_BYTES = 4;
  localparam int LEN_W = VA_W - PAGE_BITS + 1;
  localparam int NV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_ready, rsp_done, rsp_fault, mem_req;
  logic [PA_W-1:0] rsp_paddr, mem_addr;
  logic [31:0] mem_rdata = 32'hDEAD_BEEF;

  int checks = 0, failures = 0, cyc = 0, req_cnt = 0;
  logic [PA_W-1:0] last_maddr = '0;

  always #5 clk = ~clk;

  page_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PTE_BYTES(PTE_BYTES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_base_i(cfg_base), .cfg_len_i(cfg_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .rsp_done_o(rsp_done), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata));

  // entry content is a function of its address; garbage outside the data cycle
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    return a >> 2;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata  <= pte_of(mem_addr);
      req_cnt    <= req_cnt + 1;
      last_maddr <= mem_addr;
    end else begin
      mem_rdata <= 32'hDEAD_BEEF;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] b, input logic [LEN_W-1:0] l,
                                input logic [31:0] va, output logic f,
                                output logic [31:0] pa, output logic [31:0] ea);
    logic [LEN_W-1:0] p;
    logic [31:0] fr;
    p  = LEN_W'(va >> PAGE_BITS);
    f  = (p >= l);
    ea = b + (32'(p) << 2);
    fr = pte_of(ea) & ((32'h1 << (PA_W - PAGE_BITS)) - 1);
    pa = f ? 32'h0 : ((fr << PAGE_BITS) | (va & ((32'h1 << PAGE_BITS) - 1)));
  endfunction

  task automatic set_cfg(input logic [31:0] b, input logic [LEN_W-1:0] l);
    @(negedge clk); cfg_we = 1'b1; cfg_base = b; cfg_len = l;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  logic got_f;
  logic [31:0] got_pa, got_ma;
  int got_lat, got_nreq;

  task automatic run_req(input logic [31:0] va, input bit with_cfg, input logic [LEN_W-1:0] wl);
    int c0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    if (with_cfg) begin cfg_we = 1'b1; cfg_len = wl; end
    c0 = req_cnt;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    got_lat = 1;
    while (!rsp_done && got_lat < 10) begin @(negedge clk); got_lat++; end
    got_f = rsp_fault; got_pa = rsp_paddr; got_ma = last_maddr;
    got_nreq = req_cnt - c0;
  endtask

  localparam logic [31:0] V_BASE [NV] = '{32'd24, 32'h1000, 32'h1000, 32'h1000,
                                         32'h4000, 32'h200, 32'h0FFF_F000, 32'h0FFF_F000};
  localparam logic [LEN_W-1:0] V_LEN [NV] = '{23'd4, 23'd16, 23'd16, 23'd16,
                                              23'd0, 23'h40_0000, 23'd100, 23'd100};
  localparam logic [31:0] V_VA [NV] = '{32'd2500, 32'h0, 32'h3FFF, 32'h4000,
                                       32'h5, 32'hFFFF_FFFF, 32'h0001_8C33, 32'h0001_9000};

  initial begin : watchdog
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic ef;
    logic [31:0] epa, eea;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 done", 64'(rsp_done), 64'd0);
    chk("R1 mem_req", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      set_cfg(V_BASE[i], V_LEN[i]);
      model(V_BASE[i], V_LEN[i], V_VA[i], ef, epa, eea);
      run_req(V_VA[i], 1'b0, '0);
      chk($sformatf("R3/R10 fault v%0d", i), 64'(got_f), 64'(ef));
      chk($sformatf("R5/R2 paddr v%0d", i), 64'(got_pa), 64'(epa));
      chk($sformatf("R3/R5 latency v%0d", i), 64'(got_lat), ef ? 64'd2 : 64'd3);
      chk($sformatf("R4 fetch count v%0d", i), 64'(got_nreq), ef ? 64'd0 : 64'd1);
      if (!ef) chk($sformatf("R4 entry addr v%0d", i), 64'(got_ma), 64'(eea));
      if (i == 0) chk("R6 2500->8644", 64'(got_pa), 64'd8644);
      @(negedge clk);
      chk($sformatf("R9 pulse v%0d", i), 64'(rsp_done), 64'd0);
    end

    // R7/R8: second request and config write while busy
    set_cfg(32'h1000, 23'd16);
    begin
      int c0;
      @(negedge clk); req_valid = 1'b1; req_vaddr = 32'h0000_0400;
      c0 = req_cnt;
      @(negedge clk);
      req_vaddr = 32'h0000_2C00; cfg_we = 1'b1; cfg_len = 23'd0;
      chk("R7 not ready in lookup", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk("R7 not ready in wait", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk("R7 done for first", 64'(rsp_done), 64'd1);
      req_valid = 1'b0; cfg_we = 1'b0;
      model(32'h1000, 23'd16, 32'h400, ef, epa, eea);
      chk("R7 first paddr", 64'(rsp_paddr), 64'(epa));
      chk("R7 one fetch", 64'(req_cnt - c0), 64'd1);
      @(negedge clk);
      chk("R7 busy request dropped", 64'(rsp_done | mem_req), 64'd0);
    end
    run_req(32'h0000_1400, 1'b0, '0);
    chk("R8 busy write dropped", 64'(got_f), 64'd0);

    // R8: write in the accepting cycle is dropped
    run_req(32'h0000_0C00, 1'b1, 23'd2);
    chk("R8 accept-cycle uses old len", 64'(got_f), 64'd0);
    run_req(32'h0000_0C00, 1'b0, '0);
    model(32'h1000, 23'd16, 32'h0C00, ef, epa, eea);
    chk("R8 accept-cycle write dropped", 64'(got_f), 64'd0);
    chk("R8 paddr", 64'(got_pa), 64'(epa));

    // R10 boundary on tight table
    set_cfg(32'h80, 23'd3);
    run_req(32'h0000_0BFF, 1'b0, '0);
    model(32'h80, 23'd3, 32'h0BFF, ef, epa, eea);
    chk("R10 last page ok", 64'(got_pa), 64'(epa));
    run_req(32'h0000_0C00, 1'b0, '0);
    chk("R10 first page past", 64'(got_f), 64'd1);
    chk("R3 no fetch on fault", 64'(got_nreq), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule